// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Guard with Dead-Time Insertion

This block sits at the command input of one half-bridge leg. It turns two logic requests, one for the upper switch and one for the lower switch, into two gate-enable outputs. The two enables are never high together. A switch is only turned on after a programmable dead-time has passed with both enables low. Both request inputs pass through two-flop synchronizers of equal depth. The decision logic is the same for both sides, so the upper and lower paths have identical turn-on and turn-off latency.

Two supervisor inputs, synchronous to `clk`, act on the leg. `hold` freezes both enables and the dead-time count. `force_off` drives both enables low at the next edge and overrides `hold` and any dead-time wait. A leg controller uses the block by driving `hi_cmd`/`lo_cmd` from its modulator and feeding `hi_gate`/`lo_gate` to the level shifters.

The control is one state machine with five states: `ST_OFF` (both low), `ST_WAIT_HI` and `ST_WAIT_LO` (dead-time running before the named side turns on), `ST_HI_ON` and `ST_LO_ON`. Its transitions are:
- start-high: `ST_OFF`→`ST_WAIT_HI`
- start-low: `ST_OFF`→`ST_WAIT_LO`
- expire-high: `ST_WAIT_HI`→`ST_HI_ON`
- expire-low: `ST_WAIT_LO`→`ST_LO_ON`
- abandon: `ST_WAIT_*`→`ST_OFF` when the request drops
- redirect: `ST_WAIT_HI`↔`ST_WAIT_LO` when the other side is requested
- release: `ST_*_ON`→`ST_OFF`
- handover: `ST_HI_ON`→`ST_WAIT_LO` or `ST_LO_ON`→`ST_WAIT_HI`
- kill: any state→`ST_OFF` under `force_off`

Every entry into a wait state restarts the dead-time timer.

Top module: `hbg_leg_guard`

## Requirements
- R1: When `hi_cmd` and `lo_cmd` are both 1, both gate enables are 0 from the third rising edge after the inputs change, and they stay 0 while both inputs remain high.
- R2: A gate enable never rises unless both enables have been 0 for at least `DT_CYCLES` clock cycles. On a direct handover (one request drops as the other rises), the gap between one enable falling and the other rising is exactly `DT_CYCLES` cycles.
- R3: The latency from a request input to its gate enable is identical for both sides. Turn-off takes effect 3 rising edges after the input falls. Turn-on from the all-off state takes effect `DT_CYCLES`+3 rising edges after the input rises.
- R4: With exactly one request high and no `hold` or `force_off`, the matching enable follows that request and the opposite enable stays 0.
- R5: While `hold` is 1 (and `force_off` is 0), both enables keep their values and the dead-time count is frozen. After `hold` is released, the machine acts on the current synchronized requests, and any frozen count resumes from where it stopped.
- R6: When `force_off` is 1 at a rising edge, both enables are 0 after that edge, even while `hold` is 1 or a dead-time is running. After release, a turn-on still waits a full `DT_CYCLES` count.
- R7: If a request drops before its dead-time completes, the count is discarded. A later request waits a full `DT_CYCLES` count from a fresh start.
- R8: Reset (`rst_n` = 0, asynchronous) clears both enables and the synchronizers at once. After release, a held request needs the full `DT_CYCLES`+3 edges to turn on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | Upper switch request (asynchronous, synchronized inside) |
| lo_cmd | input | 1 | Lower switch request (asynchronous, synchronized inside) |
| force_off | input | 1 | Supervisor kill, synchronous, active high |
| hold | input | 1 | Supervisor freeze, synchronous, active high |
| hi_gate | output | 1 | Upper gate enable |
| lo_gate | output | 1 | Lower gate enable |

## Verification
Each result falls due at a fixed edge count after its stimulus:
- a request edge reaches an enable after 3 edges when turning off and after `DT_CYCLES`+3 edges when turning on from idle;
- a handover shows a low gap of exactly `DT_CYCLES` cycles;
- `hold` and `force_off` act at the very next edge.

The stimulus table stores, for every step, the number of rising edges to wait. It then samples on the falling edge after the last of them. Wherever an enable is about to change, the table checks the cycle before the change (old value) and the cycle of the change (new value). A transition one cycle early or late is therefore caught. This includes the resumed count after a hold and the restarted count after an abandoned request.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_WAIT_HI = 3'd1,
        ST_HI_ON   = 3'd2,
        ST_WAIT_LO = 3'd3,
        ST_LO_ON   = 3'd4
    } leg_state_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_req_t;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Each bit gets its own chain of equal depth, so every path has the same latency.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/hbg_req_decode.sv
module hbg_req_decode
    import hbg_pkg::*;
(
    input  logic     hi_s,
    input  logic     lo_s,
    output leg_req_t want
);
    // A conflicting pair resolves to "neither": no side wins priority.
    always_comb begin
        want.hi = hi_s & ~lo_s;
        want.lo = lo_s & ~hi_s;
    end

endmodule

// File: rtl/hbg_dt_timer.sv
module hbg_dt_timer #(
    parameter int DT_CYCLES = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = (DT_CYCLES > 1) ? $clog2(DT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q == LAST);

endmodule

// File: rtl/hbg_leg_fsm.sv
module hbg_leg_fsm
    import hbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_t want,
    input  logic     hold,
    input  logic     force_off,
    input  logic     tmr_done,
    output logic     tmr_clr,
    output logic     tmr_en,
    output logic     hi_gate,
    output logic     lo_gate
);
    leg_state_t state_q;
    leg_state_t state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next state and timer control
    always_comb begin
        state_nxt = state_q;
        tmr_clr   = 1'b0;
        tmr_en    = 1'b0;
        if (force_off) begin
            state_nxt = ST_OFF;                     // kill
        end else if (!hold) begin
            unique case (state_q)
                ST_OFF: begin
                    if (want.hi) begin
                        state_nxt = ST_WAIT_HI;     // start-high
                        tmr_clr   = 1'b1;
                    end else if (want.lo) begin
                        state_nxt = ST_WAIT_LO;     // start-low
                        tmr_clr   = 1'b1;
                    end
                end
                ST_WAIT_HI: begin
                    if (want.lo) begin
                        state_nxt = ST_WAIT_LO;     // redirect
                        tmr_clr   = 1'b1;
                    end else if (!want.hi) begin
                        state_nxt = ST_OFF;         // abandon
                    end else if (tmr_done) begin
                        state_nxt = ST_HI_ON;       // expire-high
                    end else begin
                        tmr_en = 1'b1;
                    end
                end
                ST_HI_ON: begin
                    if (want.lo) begin
                        state_nxt = ST_WAIT_LO;     // handover
                        tmr_clr   = 1'b1;
                    end else if (!want.hi) begin
                        state_nxt = ST_OFF;         // release
                    end
                end
                ST_WAIT_LO: begin
                    if (want.hi) begin
                        state_nxt = ST_WAIT_HI;     // redirect
                        tmr_clr   = 1'b1;
                    end else if (!want.lo) begin
                        state_nxt = ST_OFF;         // abandon
                    end else if (tmr_done) begin
                        state_nxt = ST_LO_ON;       // expire-low
                    end else begin
                        tmr_en = 1'b1;
                    end
                end
                ST_LO_ON: begin
                    if (want.hi) begin
                        state_nxt = ST_WAIT_HI;     // handover
                        tmr_clr   = 1'b1;
                    end else if (!want.lo) begin
                        state_nxt = ST_OFF;         // release
                    end
                end
                default: state_nxt = ST_OFF;
            endcase
        end
    end

    // Registered outputs, decoded from the next state so they line up with state_q
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_gate <= 1'b0;
            lo_gate <= 1'b0;
        end else begin
            hi_gate <= (state_nxt == ST_HI_ON);
            lo_gate <= (state_nxt == ST_LO_ON);
        end
    end

    // R4: a dropped request with no supervisor action leaves the on state
    a_r4_drop_turns_off_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI_ON && !force_off && !hold && !want.hi) |=> (state_q != ST_HI_ON));
    a_r4_drop_turns_off_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LO_ON && !force_off && !hold && !want.lo) |=> (state_q != ST_LO_ON));

endmodule

// File: rtl/hbg_leg_guard.sv
module hbg_leg_guard
    import hbg_pkg::*;
#(
    parameter int DT_CYCLES   = 33,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic force_off,
    input  logic hold,
    output logic hi_gate,
    output logic lo_gate
);
    logic [1:0] cmd_s;
    leg_req_t   want;
    logic       tmr_clr;
    logic       tmr_en;
    logic       tmr_done;

    hbg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({hi_cmd, lo_cmd}),
        .dout (cmd_s)
    );

    hbg_req_decode u_dec (
        .hi_s(cmd_s[1]),
        .lo_s(cmd_s[0]),
        .want(want)
    );

    hbg_dt_timer #(.DT_CYCLES(DT_CYCLES)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .en   (tmr_en),
        .done (tmr_done)
    );

    hbg_leg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .hold     (hold),
        .force_off(force_off),
        .tmr_done (tmr_done),
        .tmr_clr  (tmr_clr),
        .tmr_en   (tmr_en),
        .hi_gate  (hi_gate),
        .lo_gate  (lo_gate)
    );

    // Window counter for the dead-gap check: cycles with both enables low, saturating.
    localparam int IW = $clog2(DT_CYCLES + 1);
    localparam logic [IW-1:0] GAP_MAX = IW'(DT_CYCLES);
    logic [IW-1:0] idle_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_run_q <= '0;
        end else if (hi_gate || lo_gate) begin
            idle_run_q <= '0;
        end else if (idle_run_q != GAP_MAX) begin
            idle_run_q <= idle_run_q + IW'(1);
        end
    end

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_gate && lo_gate));

    a_r2_hi_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate) |-> (idle_run_q >= GAP_MAX));

    a_r2_lo_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate) |-> (idle_run_q >= GAP_MAX));

    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !force_off) |=> ($stable(hi_gate) && $stable(lo_gate)));

    a_r6_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!hi_gate && !lo_gate));

endmodule

// File: tb/hbg_leg_guard_tb_top.sv
module hbg_leg_guard_tb_top;

    localparam int DT  = 5;
    localparam int ON  = DT + 3;   // idle-to-on latency in edges (R3)
    localparam int OFF = 3;        // turn-off latency in edges (R3)
    localparam int NV  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd = 1'b0;
    logic force_off = 1'b0;
    logic hold = 1'b0;
    logic hi_gate;
    logic lo_gate;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hbg_leg_guard #(.DT_CYCLES(DT), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_cmd   (hi_cmd),
        .lo_cmd   (lo_cmd),
        .force_off(force_off),
        .hold     (hold),
        .hi_gate  (hi_gate),
        .lo_gate  (lo_gate)
    );

    // Layout: [17] hi, [16] lo, [15] hold, [14] force, [13:6] edges, [5] exp hi, [4] exp lo, [3:0] requirement
    localparam logic [17:0] VEC [NV] = '{
        {4'b1000, 8'(ON-1),  2'b00, 4'd3},  // R3 not on one edge early
        {4'b1000, 8'd1,      2'b10, 4'd4},  // R4 high side follows
        {4'b0000, 8'(OFF-1), 2'b10, 4'd3},  // R3 still on
        {4'b0000, 8'd1,      2'b00, 4'd3},  // R3 off after 3 edges
        {4'b0100, 8'(ON-1),  2'b00, 4'd3},  // R3 low side same latency
        {4'b0100, 8'd1,      2'b01, 4'd4},  // R4 low side follows
        {4'b0000, 8'(OFF-1), 2'b01, 4'd3},
        {4'b0000, 8'd1,      2'b00, 4'd3},
        {4'b1000, 8'(ON),    2'b10, 4'd4},
        {4'b0100, 8'(OFF),   2'b00, 4'd2},  // R2 handover: high drops
        {4'b0100, 8'(DT-1),  2'b00, 4'd2},  // R2 gap not yet complete
        {4'b0100, 8'd1,      2'b01, 4'd2},  // R2 exact gap
        {4'b1100, 8'(OFF),   2'b00, 4'd1},  // R1 both high -> off
        {4'b1100, 8'd20,     2'b00, 4'd1},  // R1 stays off
        {4'b0000, 8'd5,      2'b00, 4'd4},
        {4'b1000, 8'(DT),    2'b00, 4'd7},  // R7 request shorter than dead-time
        {4'b0000, 8'd1,      2'b00, 4'd7},
        {4'b1000, 8'(ON-1),  2'b00, 4'd7},  // R7 count restarted
        {4'b1000, 8'd1,      2'b10, 4'd7},
        {4'b0110, 8'd10,     2'b10, 4'd5},  // R5 hold freezes on state
        {4'b0100, 8'd1,      2'b00, 4'd5},
        {4'b0100, 8'(DT-1),  2'b00, 4'd5},
        {4'b0100, 8'd1,      2'b01, 4'd5},
        {4'b1000, 8'(OFF),   2'b00, 4'd4},
        {4'b1010, 8'd10,     2'b00, 4'd5},  // R5 hold freezes the count
        {4'b1000, 8'(DT-1),  2'b00, 4'd5},
        {4'b1000, 8'd1,      2'b10, 4'd5},  // R5 count resumed
        {4'b1011, 8'd1,      2'b00, 4'd6},  // R6 force beats hold
        {4'b1001, 8'd5,      2'b00, 4'd6},
        {4'b1000, 8'(DT),    2'b00, 4'd6},  // R6 full dead-time after release
        {4'b1000, 8'd1,      2'b10, 4'd6},
        {4'b0000, 8'(OFF),   2'b00, 4'd4}
    };

    task automatic check(input logic eh, input logic el, input int req);
        checks++;
        if (hi_gate !== eh || lo_gate !== el) begin
            failures++;
            $display("FAIL R%0d: hi_gate=%b lo_gate=%b expected hi_gate=%b lo_gate=%b",
                     req, hi_gate, lo_gate, eh, el);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check(1'b0, 1'b0, 8);
        rst_n = 1'b1;
        wait_edges(2);
        check(1'b0, 1'b0, 8);

        for (int i = 0; i < NV; i++) begin
            hi_cmd    = VEC[i][17];
            lo_cmd    = VEC[i][16];
            hold      = VEC[i][15];
            force_off = VEC[i][14];
            wait_edges(int'(VEC[i][13:6]));
            check(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
        end

        // R8: asynchronous reset while a gate is on
        hi_cmd = 1'b1;
        wait_edges(ON);
        check(1'b1, 1'b0, 3);
        rst_n = 1'b0;
        #1;
        check(1'b0, 1'b0, 8);
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(ON - 1);
        check(1'b0, 1'b0, 8);
        wait_edges(1);
        check(1'b1, 1'b0, 8);

        // R1: a one-edge overlap of both requests still turns the high side off
        lo_cmd = 1'b1;
        wait_edges(1);
        lo_cmd = 1'b0;
        wait_edges(OFF - 1);
        check(1'b0, 1'b0, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule